// File: doc/BRIEF.md
# Hot-plug slot command completion tracker

This block holds the slot control and slot status registers of a hot-plug capable downstream port. It also decides which configuration writes to slot control count as hot-plug commands. Software reaches both registers through a plain 16-bit register port. Each detected command carries a snapshot of the physical control fields to a slot power and indicator controller over a valid/ack handshake. The command-completed flag is raised only once that controller has taken the snapshot.

The parameter `LEGACY_MODE` selects how commands are detected:

- With `LEGACY_MODE = 0`, every write to slot control is a command.
- With `LEGACY_MODE = 1`, a write is a command only when it changes one of the four physical control fields. Writes that touch only notification-enable bits update the register but never complete.

The parameter `HP_CAPABLE = 0` turns the port into one that never issues commands. A command written while another is still being delivered is held as pending and issued right after the current ack.

Top module: `hp_slot_cmd_tracker`

## Requirements
- R1: After reset the slot control register reads 0, the completed flag (status bit 4) reads 0, and cmd_valid_o is low.
- R2: Every bit written to slot control (address A8h) reads back as written, in every mode, including bits outside the control fields.
- R3: In legacy mode, a slot control write that changes bits 7:6, 9:8, 10 or 11 raises cmd_valid_o in the next cycle. cmd_ctrl_o then carries the new bits 11:6, with bit 0 of cmd_ctrl_o equal to register bit 6.
- R4: In legacy mode, a slot control write that leaves bits 11:6 unchanged raises neither cmd_valid_o nor the completed flag.
- R5: In spec-conforming mode, every slot control write issues a command, even one that rewrites the same value.
- R6: While cmd_valid_o is high and cmd_ack_i is low, cmd_valid_o stays high and cmd_ctrl_o stays stable.
- R7: The completed flag (slot status, address AAh, bit 4) becomes 1 in the cycle after the edge where cmd_valid_o and cmd_ack_i are both high, and not earlier.
- R8: Writing slot status with bit 4 set clears the completed flag. Writing it with bit 4 clear leaves the flag unchanged.
- R9: Commands written while one is in flight merge into one pending command. That command is issued in the cycle after the ack and carries the latest control fields, so one completion is reported per issued command.
- R10: With HP_CAPABLE = 0, no write ever raises cmd_valid_o or the completed flag.
- R11: Writes to slot status never issue a command, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | ADDR_W | Register address |
| cfg_wdata_i | input | 16 | Write data |
| cfg_rdata_o | output | 16 | Read data for cfg_addr_i (combinational) |
| cmd_valid_o | output | 1 | Command offered to the slot controller |
| cmd_ack_i | input | 1 | Slot controller accepts the command |
| cmd_ctrl_o | output | 6 | Control-field snapshot (register bits 11:6) |

## Verification
The bench drives three instances side by side: legacy, spec-conforming and not hot-plug capable. It walks writes that change each control field in turn and interleaves writes that touch only enable bits or upper bits. A detector that compared the whole register, or compared nothing, would issue commands for enable-only writes in legacy mode or miss same-value writes in spec mode. Separate checks catch a flag that rises at the write instead of after the ack, and a clear that fires on a written 0. A burst of writes during an in-flight command exposes a queue that drops the pending command, issues it twice or ships stale control values.

// File: rtl/hp_pkg.sv
package hp_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned CTRL_LO = 6;
  localparam int unsigned CTRL_HI = 11;
  localparam int unsigned CTRL_W  = CTRL_HI - CTRL_LO + 1;
  localparam int unsigned CC_BIT  = 4;

  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [REG_W-1:0]  reg_t;
endpackage

// File: rtl/hp_cmd_detect.sv
module hp_cmd_detect
  import hp_pkg::*;
#(
  parameter bit LEGACY_MODE = 1'b1,
  parameter bit HP_CAPABLE  = 1'b1
) (
  input  logic  ctrl_wr_i,
  input  ctrl_t old_ctrl_i,
  input  ctrl_t new_ctrl_i,
  output logic  is_cmd_o
);
  logic changed;

  // attention, power indicator, power controller, interlock
  assign changed = (old_ctrl_i[1:0] != new_ctrl_i[1:0]) ||
                   (old_ctrl_i[3:2] != new_ctrl_i[3:2]) ||
                   (old_ctrl_i[4]   != new_ctrl_i[4])   ||
                   (old_ctrl_i[5]   != new_ctrl_i[5]);

  generate
    if (!HP_CAPABLE) begin : g_incap
      assign is_cmd_o = 1'b0;
    end else if (LEGACY_MODE) begin : g_legacy
      assign is_cmd_o = ctrl_wr_i && changed;
    end else begin : g_spec
      assign is_cmd_o = ctrl_wr_i;
    end
  endgenerate
endmodule

// File: rtl/hp_cmd_queue.sv
module hp_cmd_queue
  import hp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmd_i,
  input  ctrl_t snap_i,
  input  logic  ack_i,
  output logic  valid_o,
  output ctrl_t data_o,
  output logic  done_o
);
  logic  valid_q, pending_q;
  ctrl_t data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      pending_q <= 1'b0;
      data_q    <= '0;
    end else if (valid_q && ack_i) begin
      // back-to-back issue of a merged pending command
      if (pending_q || cmd_i) begin
        data_q <= snap_i;
      end else begin
        valid_q <= 1'b0;
      end
      pending_q <= 1'b0;
    end else if (valid_q) begin
      if (cmd_i) pending_q <= 1'b1;
    end else if (cmd_i) begin
      valid_q <= 1'b1;
      data_q  <= snap_i;
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
  assign done_o  = valid_q && ack_i;

  p_valid_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ack_i |=> valid_q);
  p_data_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && !ack_i |=> $stable(data_q));
  p_pending_issue_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q && ack_i && pending_q |=> valid_q);
endmodule

// File: rtl/hp_cmd_status.sv
module hp_cmd_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic cc_o
);
  logic cc_q;

  // completion wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cc_q <= 1'b0;
    else if (set_i) cc_q <= 1'b1;
    else if (clr_i) cc_q <= 1'b0;
  end

  assign cc_o = cc_q;

  p_cc_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cc_q) |-> $past(set_i));
endmodule

// File: rtl/hp_slot_cmd_tracker.sv
module hp_slot_cmd_tracker
  import hp_pkg::*;
#(
  parameter bit          LEGACY_MODE = 1'b1,
  parameter bit          HP_CAPABLE  = 1'b1,
  parameter int unsigned ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h0A8,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 12'h0AA
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  output logic [15:0]       cfg_rdata_o,
  output logic              cmd_valid_o,
  input  logic              cmd_ack_i,
  output logic [5:0]        cmd_ctrl_o
);
  reg_t  ctrl_q, ctrl_d;
  logic  ctrl_wr, stat_wr, is_cmd, done, cc;
  ctrl_t snap;

  assign ctrl_wr = cfg_wr_i && (cfg_addr_i == CTRL_ADDR);
  assign stat_wr = cfg_wr_i && (cfg_addr_i == STAT_ADDR);
  assign ctrl_d  = ctrl_wr ? cfg_wdata_i : ctrl_q;
  assign snap    = ctrl_d[CTRL_HI:CTRL_LO];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  hp_cmd_detect #(
    .LEGACY_MODE(LEGACY_MODE),
    .HP_CAPABLE (HP_CAPABLE)
  ) i_detect (
    .ctrl_wr_i (ctrl_wr),
    .old_ctrl_i(ctrl_q[CTRL_HI:CTRL_LO]),
    .new_ctrl_i(cfg_wdata_i[CTRL_HI:CTRL_LO]),
    .is_cmd_o  (is_cmd)
  );

  hp_cmd_queue i_queue (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_i  (is_cmd),
    .snap_i (snap),
    .ack_i  (cmd_ack_i),
    .valid_o(cmd_valid_o),
    .data_o (cmd_ctrl_o),
    .done_o (done)
  );

  hp_cmd_status i_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (done),
    .clr_i (stat_wr && cfg_wdata_i[CC_BIT]),
    .cc_o  (cc)
  );

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == CTRL_ADDR)      cfg_rdata_o = ctrl_q;
    else if (cfg_addr_i == STAT_ADDR) cfg_rdata_o[CC_BIT] = cc;
  end

  p_cc_after_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cc) |-> $past(cmd_valid_o && cmd_ack_i));
  p_no_cmd_incap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !HP_CAPABLE |-> !cmd_valid_o);
  p_stat_no_cmd_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && !cmd_valid_o |=> !cmd_valid_o);
endmodule

// File: tb/test_hp_slot_cmd_tracker.sv
module test_hp_slot_cmd_tracker;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'h0A8;
  localparam logic [11:0] A_STAT = 12'h0AA;
  localparam int NVEC = 10;
  // {legacy expects command, write data}
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'h0040}, {1'b0, 16'h0048}, {1'b1, 16'h0148}, {1'b1, 16'h0548},
    {1'b1, 16'h0D48}, {1'b0, 16'h0D7F}, {1'b0, 16'hFD7F}, {1'b0, 16'hFD7F},
    {1'b1, 16'h0000}, {1'b1, 16'h00BF}};

  logic clk = 1'b0, rst_n = 1'b0, wr = 1'b0, ack = 1'b0;
  logic [11:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rd_l, rd_s, rd_i;
  logic v_l, v_s, v_i;
  logic [5:0] c_l, c_s, c_i;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hp_slot_cmd_tracker #(.LEGACY_MODE(1'b1), .HP_CAPABLE(1'b1)) i_hp_slot_cmd_tracker (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rd_l), .cmd_valid_o(v_l), .cmd_ack_i(ack), .cmd_ctrl_o(c_l));
  hp_slot_cmd_tracker #(.LEGACY_MODE(1'b0), .HP_CAPABLE(1'b1)) i_spec (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rd_s), .cmd_valid_o(v_s), .cmd_ack_i(ack), .cmd_ctrl_o(c_s));
  hp_slot_cmd_tracker #(.LEGACY_MODE(1'b0), .HP_CAPABLE(1'b0)) i_incap (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
    .cfg_rdata_o(rd_i), .cmd_valid_o(v_i), .cmd_ack_i(ack), .cmd_ctrl_o(c_i));

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic set_addr(input logic [11:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*2);
    // R1 reset state
    set_addr(A_CTRL);
    check(rd_l, 16'h0, "R1 ctrl"); check(rd_s, 16'h0, "R1 ctrl spec");
    set_addr(A_STAT);
    check(rd_l, 16'h0, "R1 status");
    check({15'b0, v_l | v_s}, 16'h0, "R1 valid");
    rst_n = 1'b1;

    for (int k = 0; k < NVEC; k++) begin
      logic exp_cmd;
      logic [15:0] d;
      exp_cmd = VEC[k][16];
      d = VEC[k][15:0];
      cfg_write(A_CTRL, d);
      check({15'b0, v_l}, {15'b0, exp_cmd}, exp_cmd ? "R3 legacy valid" : "R4 legacy no valid");
      check({15'b0, v_s}, 16'h1, "R5 spec valid");
      check({15'b0, v_i}, 16'h0, "R10 incap valid");
      check({10'b0, c_s}, {10'b0, d[11:6]}, "R3 spec snapshot");
      if (exp_cmd) check({10'b0, c_l}, {10'b0, d[11:6]}, "R3 legacy snapshot");
      set_addr(A_STAT);
      check(rd_s, 16'h0, "R7 flag not before ack");
      @(negedge clk);
      check({15'b0, v_s}, 16'h1, "R6 valid held");
      pulse_ack();
      check({13'b0, v_l, v_s, v_i}, 16'h0, "R6 valid drops after ack");
      set_addr(A_STAT);
      check(rd_l, {11'b0, exp_cmd, 4'b0}, exp_cmd ? "R7 legacy flag" : "R4 legacy no flag");
      check(rd_s, 16'h0010, "R7 spec flag");
      check(rd_i, 16'h0, "R10 incap flag");
      set_addr(A_CTRL);
      check(rd_l, d, "R2 legacy readback");
      check(rd_s, d, "R2 spec readback");
      check(rd_i, d, "R2 incap readback");
      cfg_write(A_STAT, 16'h0010);
      check({15'b0, v_s}, 16'h0, "R11 status write no cmd");
      set_addr(A_STAT);
      check(rd_l | rd_s, 16'h0, "R8 cleared");
    end

    // R8 writing 0 keeps the flag
    cfg_write(A_CTRL, 16'h0100);
    pulse_ack();
    cfg_write(A_STAT, 16'hFFEF);
    set_addr(A_STAT);
    check(rd_s, 16'h0010, "R8 zero write keeps flag");
    check(rd_l, 16'h0010, "R8 zero write keeps flag legacy");
    cfg_write(A_STAT, 16'h0010);
    set_addr(A_STAT);
    check(rd_s, 16'h0, "R8 one write clears");

    // R9 merge of pending commands
    cfg_write(A_CTRL, 16'h0040);
    check({10'b0, c_s}, 16'h0001, "R9 first snapshot");
    cfg_write(A_CTRL, 16'h0080);
    cfg_write(A_CTRL, 16'h00C0);
    check({15'b0, v_s}, 16'h1, "R6 held during writes");
    check({10'b0, c_s}, 16'h0001, "R6 snapshot stable");
    pulse_ack();
    check({15'b0, v_s}, 16'h1, "R9 pending issued");
    check({10'b0, c_s}, 16'h0003, "R9 latest fields");
    check({10'b0, c_l}, 16'h0003, "R9 legacy latest fields");
    set_addr(A_STAT);
    check(rd_s, 16'h0010, "R9 first completion");
    cfg_write(A_STAT, 16'h0010);
    pulse_ack();
    check({15'b0, v_s}, 16'h0, "R9 single pending issue");
    set_addr(A_STAT);
    check(rd_s, 16'h0010, "R9 second completion");
    cfg_write(A_STAT, 16'h0010);
    pulse_ack();
    check({15'b0, v_s}, 16'h0, "R9 no extra command");

    // R11 unmapped read
    set_addr(12'h000);
    check(rd_s, 16'h0, "R11 unmapped read");

    // R1 reset mid-run
    cfg_write(A_CTRL, 16'h0F00);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    set_addr(A_CTRL);
    check(rd_s, 16'h0, "R1 ctrl after reset");
    check({15'b0, v_s}, 16'h0, "R1 valid after reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({15'b0, v_s}, 16'h0, "R1 nothing pending");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule